// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single transfer requests from a small 8-bit processor core into external bus cycles on a bus where the low address byte and the data byte share the same pins. A request names the cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write), a 16-bit address and, for writes, a data byte. The sequencer plays the cycle out as processor states T1, T2, optional wait states, T3 and, for fetches, a fourth internal state. It pulses a done flag in the cycle after the transfer ends, and for reads it returns the captured byte with that pulse.

The block runs on a clock at twice the processor state rate. Each processor state therefore takes two clocks, a first half and a second half. This lets the block place the address latch strobe, the mid-state READY sample, the read capture point and the write data hold on half-state boundaries. All bus pins come straight from flip-flops. A new request is taken only while the sequencer is idle.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While reset is high and after it is released with no request pending: `idle`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `io_m`=0 and `s1`/`s0`=00.
- R2: In T1 `ale` is high for the first half-state only, exactly once per cycle. While `ale` is high, `ad_oe`=1, `ad_out` carries address bits 7:0 and `addr_hi` carries bits 15:8. No strobe is low while `ale` is high.
- R3: From T1 until the last busy clock, `{io_m,s1,s0}` holds a value set by `req_kind`: 0 fetch gives 011, 1 memory read gives 010, 2 memory write gives 001, 3 I/O read gives 110, 4 I/O write gives 101.
- R4: In a read or fetch, `ad_oe`=0 and `rd_n`=0 from the start of T2 to the end of T3, and `wr_n` is never low at the same time. The byte on `ad_in` is captured at the end of the first half of T3, one half-state before `rd_n` rises.
- R5: In a write, `ad_oe`=1 with the write byte on `ad_out` from T2 onward, and `wr_n` is low from the start of T2 to the middle of T3. The byte and `ad_oe` stay driven for the half-state after `wr_n` rises.
- R6: `ready_in` is sampled at the end of the first half of T2 and of each wait state. Each low sample adds one wait state of two clocks, during which every output is frozen. A strobe therefore lasts 2N+4 clocks for a read and 2N+3 clocks for a write, where N is the number of low samples.
- R7: With no waits, a memory or I/O cycle keeps the block busy (`idle`=0) for 3 states (6 clocks) and a fetch for 4 states (8 clocks). A fetch followed by a memory write totals 7 states (14 clocks).
- R8: `done` is high for exactly one clock, the first idle clock after a cycle. For reads and fetches, `rdata` holds the captured byte in that clock.
- R9: `req_valid` is ignored while the block is busy. Such a request starts no cycle, causes no `done` pulse and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor state rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 3 | Cycle kind code (see R3) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| idle | output | 1 | Sequencer is idle and can take a request |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Captured read byte |
| ale | output | 1 | Address latch strobe |
| ad_out | output | 8 | Low address / data byte driven onto the shared pins |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_in | input | 8 | Byte read from the shared pins |
| addr_hi | output | 8 | High address byte |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for an I/O cycle, low for a memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready_in | input | 1 | Slave ready, low requests wait states |

## Verification
Two situations are the hardest to reach from the ports. The first is a read whose data is valid only up to the capture point. The second is a request raised while a cycle is in flight. The memory model in the bench tracks how many clocks each strobe has been low. From that count it holds `ready_in` low for a chosen number of samples. It also replaces the read byte with a poison value in the final half-state of T3, so any capture made later than the first half of T3 returns the wrong byte. One read with three waits has a write request to a separate address raised and dropped in its middle. A later read of that address through the bus shows the stray request wrote nothing.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4,
    S_T4   = 3'd5
  } st_e;

  function automatic logic is_write(kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  // {io_m, s1, s0}
  function automatic logic [2:0] status_of(kind_e k);
    case (k)
      K_FETCH: return 3'b011;
      K_MRD:   return 3'b010;
      K_MWR:   return 3'b001;
      K_IORD:  return 3'b110;
      K_IOWR:  return 3'b101;
      default: return 3'b010;
    endcase
  endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready_in,
  output st_e               st,
  output logic              ph,
  output st_e               st_nxt,
  output logic              ph_nxt,
  output kind_e             kind_q,
  output kind_e             kind_nxt,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [DATA_W-1:0] wdata_nxt
);

  logic              wait_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  assign accept    = (st == S_IDLE) && req_valid;
  assign kind_nxt  = accept ? kind_e'(req_kind) : kind_q;
  assign addr_nxt  = accept ? req_addr : addr_q;
  assign wdata_nxt = accept ? req_wdata : wdata_q;

  always_comb begin
    st_nxt = st;
    ph_nxt = 1'b0;
    if (st == S_IDLE) begin
      if (req_valid) st_nxt = S_T1;
    end else if (!ph) begin
      ph_nxt = 1'b1;
    end else begin
      case (st)
        S_T1:    st_nxt = S_T2;
        S_T2:    st_nxt = wait_q ? S_TW : S_T3;
        S_TW:    st_nxt = wait_q ? S_TW : S_T3;
        S_T3:    st_nxt = (kind_q == K_FETCH) ? S_T4 : S_IDLE;
        S_T4:    st_nxt = S_IDLE;
        default: st_nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ph      <= 1'b0;
      wait_q  <= 1'b0;
      kind_q  <= K_MRD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st      <= st_nxt;
      ph      <= ph_nxt;
      kind_q  <= kind_nxt;
      addr_q  <= addr_nxt;
      wdata_q <= wdata_nxt;
      if ((st == S_T2 || st == S_TW) && !ph)
        wait_q <= !ready_in;
    end
  end

  assert_kind_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(kind_q));

  assert_wait_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_TW && !ph && $past(st) == S_T2) |-> !$past(ready_in, 2));

  assert_no_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_T3 && !ph && $past(st) == S_T2) |-> $past(ready_in, 2));

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  st_e               st_nxt,
  input  logic              ph_nxt,
  input  kind_e             kind_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [DATA_W-1:0] wdata_nxt,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0
);

  logic              n_ale, n_oe, n_rd, n_wr;
  logic [DATA_W-1:0] n_out;
  logic [HI_W-1:0]   n_hi;
  logic [2:0]        n_stat;
  logic              wr_kind;

  assign wr_kind = is_write(kind_nxt);

  always_comb begin
    n_ale  = 1'b0;
    n_oe   = 1'b0;
    n_rd   = 1'b1;
    n_wr   = 1'b1;
    n_out  = '0;
    n_hi   = '0;
    n_stat = 3'b000;
    if (st_nxt != S_IDLE) begin
      n_hi   = addr_nxt[ADDR_W-1:DATA_W];
      n_stat = status_of(kind_nxt);
    end
    case (st_nxt)
      S_T1: begin
        n_oe  = 1'b1;
        n_out = addr_nxt[DATA_W-1:0];
        n_ale = !ph_nxt;
      end
      S_T2, S_TW: begin
        if (wr_kind) begin
          n_oe  = 1'b1;
          n_out = wdata_nxt;
          n_wr  = 1'b0;
        end else begin
          n_rd = 1'b0;
        end
      end
      S_T3: begin
        if (wr_kind) begin
          n_oe  = 1'b1;
          n_out = wdata_nxt;
          n_wr  = ph_nxt;
        end else begin
          n_rd = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      addr_hi <= '0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      io_m    <= 1'b0;
      s1      <= 1'b0;
      s0      <= 1'b0;
    end else begin
      ale     <= n_ale;
      ad_oe   <= n_oe;
      ad_out  <= n_out;
      addr_hi <= n_hi;
      rd_n    <= n_rd;
      wr_n    <= n_wr;
      {io_m, s1, s0} <= n_stat;
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_ale_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && ad_oe));

  assert_read_float_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

endmodule

// File: rtl/mbus_rd_capture.sv
module mbus_rd_capture
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  st_e               st,
  input  logic              ph,
  input  st_e               st_nxt,
  input  kind_e             kind_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= (st != S_IDLE) && (st_nxt == S_IDLE);
      if (st == S_T3 && !ph && !is_write(kind_q))
        rdata <= ad_in;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == S_IDLE));

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  input  logic              ready_in
);

  st_e               st, st_nxt;
  logic              ph, ph_nxt;
  kind_e             kind_q, kind_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] wdata_nxt;

  assign idle = (st == S_IDLE);

  mbus_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready_in(ready_in),
    .st(st), .ph(ph), .st_nxt(st_nxt), .ph_nxt(ph_nxt),
    .kind_q(kind_q), .kind_nxt(kind_nxt), .addr_nxt(addr_nxt),
    .wdata_nxt(wdata_nxt)
  );

  mbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .ph_nxt(ph_nxt),
    .kind_nxt(kind_nxt), .addr_nxt(addr_nxt), .wdata_nxt(wdata_nxt),
    .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0)
  );

  mbus_rd_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst(rst), .st(st), .ph(ph), .st_nxt(st_nxt),
    .kind_q(kind_q), .ad_in(ad_in), .rdata(rdata), .done(done)
  );

  assert_frozen_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_TW && $past(st) == S_TW) |->
      ($stable(rd_n) && $stable(wr_n) && $stable(ad_oe) && $stable(ad_out) && !ale));

  assert_busy_no_done_R9: assert property (@(posedge clk) disable iff (rst)
    (!idle && st_nxt != S_IDLE) |=> !done);

endmodule

// File: tb/mbus_cycle_seq_tb_top.sv
module mbus_cycle_seq_tb_top;
  import mbus_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        idle, done, ale, ad_oe, rd_n, wr_n, io_m, s1, s0;
  logic [7:0]  rdata, ad_out, addr_hi;
  logic [7:0]  ad_in = '0;
  logic        ready_in = 1'b1;

  always #5 clk = ~clk;

  mbus_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done),
    .rdata(rdata), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1),
    .s0(s0), .ready_in(ready_in)
  );

  typedef struct {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  exp_rd;
    int          nwait;
  } item_t;

  item_t       sb_q[$];
  logic [7:0]  bus_mem [256];
  logic [7:0]  ref_mem [256];
  int          checks = 0, errors = 0;
  int          sidx = 0, busy_cnt = 0, ale_cnt = 0, tot_busy = 0;
  logic [15:0] lat_addr = '0;
  logic        prev_wr = 1'b1, prev_done = 1'b0;
  bit          finished = 0;

  function automatic logic [2:0] exp_stat(logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  function automatic bit kind_wr(logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory model and monitor/scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (!rd_n || !wr_n) begin
        if (sb_q.size() > 0) begin
          ready_in = !(sidx < 2 * sb_q[0].nwait - 1);
          ad_in    = (sidx == 2 * sb_q[0].nwait + 3) ? 8'hEE : bus_mem[lat_addr[7:0]];
        end
        sidx++;
      end else begin
        ready_in = 1'b1;
        ad_in    = 8'h00;
      end

      if (!idle) begin
        busy_cnt++;
        tot_busy++;
        if (sb_q.size() > 0)
          chk({io_m, s1, s0} == exp_stat(sb_q[0].kind), "R3", "status",
              {io_m, s1, s0}, exp_stat(sb_q[0].kind));
      end

      if (ale) begin
        ale_cnt++;
        lat_addr = {addr_hi, ad_out};
        chk(ad_oe, "R2", "ad_oe at ale", ad_oe, 1);
        if (sb_q.size() > 0)
          chk(lat_addr == sb_q[0].addr, "R2", "latched addr", lat_addr, sb_q[0].addr);
      end

      if (!rd_n) chk(!ad_oe, "R4", "bus floated during read", ad_oe, 0);

      if (!prev_wr && wr_n) begin
        if (sb_q.size() > 0)
          chk(ad_oe && ad_out == sb_q[0].wdata, "R5", "write data hold",
              ad_out, sb_q[0].wdata);
        bus_mem[lat_addr[7:0]] = ad_out;
      end

      if (prev_done && done) chk(0, "R8", "done longer than one clock", 1, 0);

      if (done) begin
        if (sb_q.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          item_t it;
          int exp_busy, exp_strobe;
          it = sb_q.pop_front();
          exp_busy   = 2 * (3 + it.nwait) + ((it.kind == 3'd0) ? 2 : 0);
          exp_strobe = kind_wr(it.kind) ? 2 * it.nwait + 3 : 2 * it.nwait + 4;
          chk(busy_cnt == exp_busy, "R7", "busy clocks", busy_cnt, exp_busy);
          chk(sidx == exp_strobe, "R6", "strobe clocks", sidx, exp_strobe);
          chk(ale_cnt == 1, "R2", "ale pulses", ale_cnt, 1);
          if (!kind_wr(it.kind))
            chk(rdata == it.exp_rd, "R8", "read data", rdata, it.exp_rd);
        end
        sidx = 0; busy_cnt = 0; ale_cnt = 0;
      end
      prev_wr   = wr_n;
      prev_done = done;
    end
  end

  task automatic issue(logic [2:0] k, logic [15:0] a, logic [7:0] d, int nw, bit junk);
    item_t it;
    it.kind = k; it.addr = a; it.wdata = d; it.nwait = nw;
    it.exp_rd = ref_mem[a[7:0]];
    if (kind_wr(k)) ref_mem[a[7:0]] = d;
    sb_q.push_back(it);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (junk) begin
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h0042; req_wdata = 8'h99;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!idle) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R7", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int t0;
    for (int i = 0; i < 256; i++) begin
      bus_mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(idle && !ale && rd_n && wr_n && !ad_oe && !done, "R1", "outputs in reset",
        {idle, ale, rd_n, wr_n, ad_oe, done}, 6'b101100);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(idle && rd_n && wr_n && !ad_oe && {io_m, s1, s0} == 3'b000, "R1",
        "outputs after reset", {idle, rd_n, wr_n, ad_oe, io_m, s1, s0}, 7'b1110000);

    issue(3'd0, 16'h1234, 8'h00, 0, 0);   // R7 fetch 4 states
    issue(3'd1, 16'h20AB, 8'h00, 0, 0);   // R4 memory read
    issue(3'd2, 16'h3010, 8'hC3, 0, 0);   // R5 memory write
    issue(3'd1, 16'h3010, 8'h00, 0, 0);   // R4 read back
    issue(3'd3, 16'h0077, 8'h00, 2, 0);   // R6 waits on I/O read
    issue(3'd4, 16'h0055, 8'h3C, 1, 0);   // R6 waits on I/O write
    issue(3'd3, 16'h0055, 8'h00, 0, 0);   // R4 read back
    issue(3'd0, 16'hFF80, 8'h00, 4, 0);   // R6 fetch with waits

    // R7: fetch then memory write totals seven states
    t0 = tot_busy;
    issue(3'd0, 16'h4000, 8'h00, 0, 0);
    issue(3'd2, 16'h4001, 8'hA5, 0, 0);
    chk(tot_busy - t0 == 14, "R7", "fetch+write clocks", tot_busy - t0, 14);

    // R9: request raised while busy is ignored
    issue(3'd1, 16'h0100, 8'h00, 3, 1);
    issue(3'd1, 16'h0042, 8'h00, 0, 0);
    chk(sb_q.size() == 0 && idle, "R9", "no stray cycle", sb_q.size(), 0);

    for (int j = 0; j < 6; j++)
      issue(3'(j % 5), 16'h0200 + 16'(j * 7), 8'(8'h11 * j), j % 3, 0);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule